// File: doc/BRIEF.md
# Multi-Block Transfer Ring Tracker

This block keeps the bookkeeping for a small circular set of block buffers placed between a card data path and a host. It holds no data. It holds a producer index, a consumer index, a four-bit status word and a down-counter of blocks still to be sent. In a read transfer the data path fills slots and the host empties them. In a write transfer the host fills slots and the data path empties them.

Each block-end strobe from the data path moves the index on the data-path side. If that index then lands on the host's index, the block flags a collision: an overrun when reading, an underrun when writing. Any other data-path event sets an error flag. Either flag raises `abort_o`, which tells the host to stop waiting. During a write, each transfer-complete strobe counts the block counter down. When the counter reaches the ring depth, the block pulses a strobe that tells the DMA descriptor chain to end at the current consumer slot.

Top module: `blk_ring_tracker`

## Requirements
- R1: After reset both indices are 0, `status_o` is 0, and `abort_o` and `term_o` are low.
- R2: A `start_rd_i` pulse clears both indices and sets `status_o` to 4'b0001. Bit 0 means read active, bit 1 write active, bit 2 collision and bit 3 error. When `start_rd_i` and `start_wr_i` pulse together, the read start wins.
- R3: A `start_wr_i` pulse clears both indices, clears the occupied flag, sets `status_o` to 4'b0010 and loads the block counter from `blk_cnt_i`.
- R4: In read mode, `blk_end_i` advances `wr_idx_o` by one modulo DEPTH. `host_pop_i` advances `rd_idx_o` by one modulo DEPTH, but only when the two indices differ; otherwise the pop has no effect.
- R5: In read mode, if `wr_idx_o` equals `rd_idx_o` after a block-end advance, status bit 2 is set (overrun).
- R6: In write mode, `host_push_i` advances `wr_idx_o` modulo DEPTH, unless the indices are equal and the ring is occupied. A push that makes the indices equal marks the ring occupied. `blk_end_i` advances `rd_idx_o` modulo DEPTH and clears the occupied mark.
- R7: In write mode, if `rd_idx_o` equals `wr_idx_o` after a block-end advance, status bit 2 is set (underrun).
- R8: While a read or a write is active, `dp_err_i` sets status bit 3.
- R9: `abort_o` is high exactly when status bit 2 or bit 3 is set.
- R10: In write mode, each `xfer_done_i` decrements the block counter, which holds at 0. The decrement that takes the counter to DEPTH makes `term_o` high for one cycle in the following cycle. In that cycle `term_slot_o` holds the `rd_idx_o` value seen when the strobe arrived.
- R11: `stop_i` clears status bits 0 and 1 and leaves bits 2 and 3 unchanged. While neither bit 0 nor bit 1 is set, data-path and host strobes change neither index nor any flag.
- R12: Status bits 2 and 3 stay set until the next start pulse, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_rd_i | input | 1 | Begin a read transfer (pulse) |
| start_wr_i | input | 1 | Begin a write transfer (pulse) |
| blk_cnt_i | input | CNT_W | Block count for a write, sampled with `start_wr_i` |
| stop_i | input | 1 | Close the data path |
| blk_end_i | input | 1 | Data path finished one block |
| dp_err_i | input | 1 | Data path reported an event other than block end |
| xfer_done_i | input | 1 | DMA finished moving one block (write mode) |
| host_pop_i | input | 1 | Host took one block (read mode) |
| host_push_i | input | 1 | Host supplied one block (write mode) |
| wr_idx_o | output | IDX_W | Producer index |
| rd_idx_o | output | IDX_W | Consumer index |
| status_o | output | 4 | {error, collision, write active, read active} |
| abort_o | output | 1 | Collision or error present |
| term_o | output | 1 | End the descriptor chain (one-cycle pulse) |
| term_slot_o | output | IDX_W | Slot at which the chain must end |

## Verification
The assertions assume that start pulses last one cycle. They also assume that a data-path block-end never arrives in the same cycle as a host pop or push, so each collision compares against a settled index. The stimulus drives at most one strobe per cycle and keeps write block counts inside 1 to 127. The bench sweeps every write count from 1 to 8 through the countdown and both directions through several wraps of the four-slot ring. For each of these runs it compares every output with a model that uses modulo arithmetic.

// File: rtl/ring_pkg.sv
package ring_pkg;
  // Status word layout, most significant field first
  typedef struct packed {
    logic err;     // bit 3: data-path error
    logic col;     // bit 2: overrun or underrun
    logic wr_act;  // bit 1: write transfer active
    logic rd_act;  // bit 0: read transfer active
  } ring_status_t;

  localparam ring_status_t ST_IDLE = '{err: 1'b0, col: 1'b0, wr_act: 1'b0, rd_act: 1'b0};
  localparam ring_status_t ST_READ = '{err: 1'b0, col: 1'b0, wr_act: 1'b0, rd_act: 1'b1};
  localparam ring_status_t ST_WRITE = '{err: 1'b0, col: 1'b0, wr_act: 1'b1, rd_act: 1'b0};
endpackage

// File: rtl/ring_index.sv
module ring_index #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] idx_inc_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    idx_inc_o = (idx_q == LAST) ? '0 : idx_q + IDX_W'(1);
    idx_en    = clr | adv;
    idx_d     = clr ? '0 : idx_inc_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  // R4/R6: an index never leaves the ring
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);
endmodule

// File: rtl/ring_countdown.sv
module ring_countdown #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] HIT_AT = CNT_W'(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (dec & (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - CNT_W'(1);
    hit_o  = dec & ~load & (cnt_q == HIT_AT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R10: the counter saturates at zero
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/blk_ring_tracker.sv
module blk_ring_tracker
  import ring_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 7,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rd_i,
  input  logic             start_wr_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic             stop_i,
  input  logic             blk_end_i,
  input  logic             dp_err_i,
  input  logic             xfer_done_i,
  input  logic             host_pop_i,
  input  logic             host_push_i,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [3:0]       status_o,
  output logic             abort_o,
  output logic             term_o,
  output logic [IDX_W-1:0] term_slot_o
);
  ring_status_t     st_q, st_d;
  logic             full_q, full_d;
  logic             term_q, term_d;
  logic [IDX_W-1:0] slot_q, slot_d;
  logic [IDX_W-1:0] wr_idx, rd_idx, wr_inc, rd_inc;
  logic             start, live, active;
  logic             blk_rd, blk_wr, pop_ok, push_ok;
  logic             overrun, underrun, err_ev, cd_hit;

  // Event qualification
  always_comb begin
    start   = start_rd_i | start_wr_i;
    live    = ~start & ~stop_i;
    active  = st_q.rd_act | st_q.wr_act;
    blk_rd  = live & st_q.rd_act & blk_end_i;
    blk_wr  = live & st_q.wr_act & blk_end_i;
    pop_ok  = live & st_q.rd_act & host_pop_i & (rd_idx != wr_idx);
    push_ok = live & st_q.wr_act & host_push_i & ~((wr_idx == rd_idx) & full_q);
    overrun  = blk_rd & (wr_inc == rd_idx);
    underrun = blk_wr & (rd_inc == wr_idx);
    err_ev   = live & active & dp_err_i;
  end

  ring_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_wr_idx (
    .clk(clk), .rst_n(rst_n), .clr(start), .adv(blk_rd | push_ok),
    .idx_o(wr_idx), .idx_inc_o(wr_inc));

  ring_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_rd_idx (
    .clk(clk), .rst_n(rst_n), .clr(start), .adv(blk_wr | pop_ok),
    .idx_o(rd_idx), .idx_inc_o(rd_inc));

  ring_countdown #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cd (
    .clk(clk), .rst_n(rst_n), .load(start_wr_i & ~start_rd_i),
    .load_val(blk_cnt_i), .dec(live & st_q.wr_act & xfer_done_i),
    .hit_o(cd_hit));

  // Next state
  always_comb begin
    st_d = st_q;
    if (start_rd_i)      st_d = ST_READ;
    else if (start_wr_i) st_d = ST_WRITE;
    else begin
      if (stop_i) begin
        st_d.rd_act = 1'b0;
        st_d.wr_act = 1'b0;
      end
      st_d.col = st_q.col | overrun | underrun;
      st_d.err = st_q.err | err_ev;
    end

    if (start)                         full_d = 1'b0;
    else if (push_ok && wr_inc == rd_idx) full_d = 1'b1;
    else if (blk_wr)                   full_d = 1'b0;
    else                               full_d = full_q;

    term_d = cd_hit;
    slot_d = cd_hit ? rd_idx : slot_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      full_q <= 1'b0;
      term_q <= 1'b0;
      slot_q <= '0;
    end else begin
      st_q   <= st_d;
      full_q <= full_d;
      term_q <= term_d;
      slot_q <= slot_d;
    end
  end

  assign wr_idx_o    = wr_idx;
  assign rd_idx_o    = rd_idx;
  assign status_o    = st_q;
  assign abort_o     = st_q.col | st_q.err;
  assign term_o      = term_q;
  assign term_slot_o = slot_q;

  assert_start_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd_i |=> (status_o == 4'b0001 && wr_idx_o == '0 && rd_idx_o == '0));

  assert_start_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr_i && !start_rd_i) |=> (status_o == 4'b0010 && rd_idx_o == '0));

  assert_modes_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_o[0] && status_o[1]));

  assert_idle_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[1:0] == 2'b00 && !start_rd_i && !start_wr_i)
      |=> ($stable(wr_idx_o) && $stable(rd_idx_o) && $stable(status_o[3:2])));

  assert_col_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[2] && !start_rd_i && !start_wr_i) |=> status_o[2]);

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3] && !start_rd_i && !start_wr_i) |=> status_o[3]);

  assert_term_in_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> $past(status_o[1]));
endmodule

// File: tb/sim_blk_ring_tracker.sv
module sim_blk_ring_tracker;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_rd, start_wr, stop, blk_end, dp_err, xfer_done, pop, push;
  logic [6:0] blk_cnt;
  logic [1:0] wr_idx, rd_idx, term_slot;
  logic [3:0] status;
  logic       abort, term;

  int n_tests = 0;
  int n_fail  = 0;

  // Reference state
  int m_wr, m_rd, m_st, m_cnt, m_full, m_term, m_slot;

  always #2.5 clk = ~clk;

  blk_ring_tracker u0 (
    .clk(clk), .rst_n(rst_n), .start_rd_i(start_rd), .start_wr_i(start_wr),
    .blk_cnt_i(blk_cnt), .stop_i(stop), .blk_end_i(blk_end), .dp_err_i(dp_err),
    .xfer_done_i(xfer_done), .host_pop_i(pop), .host_push_i(push),
    .wr_idx_o(wr_idx), .rd_idx_o(rd_idx), .status_o(status), .abort_o(abort),
    .term_o(term), .term_slot_o(term_slot));

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "wr_idx", int'(wr_idx), m_wr);
    chk(tag, "rd_idx", int'(rd_idx), m_rd);
    chk(tag, "status", int'(status), m_st);
    chk("R9", "abort", int'(abort), ((m_st & 12) != 0) ? 1 : 0);
    chk(tag, "term", int'(term), m_term);
    if (m_term == 1) chk(tag, "term_slot", int'(term_slot), m_slot);
  endtask

  // e: [0]start_rd [1]start_wr [2]stop [3]blk_end [4]dp_err [5]xfer_done [6]pop [7]push
  task automatic ev(input logic [7:0] e, input int n, input string tag);
    int act;
    start_rd = e[0]; start_wr = e[1]; stop = e[2]; blk_end = e[3];
    dp_err = e[4]; xfer_done = e[5]; pop = e[6]; push = e[7];
    blk_cnt = 7'(n);
    // reference update
    m_term = 0;
    act = m_st & 3;
    if (e[0]) begin
      m_wr = 0; m_rd = 0; m_st = 1; m_full = 0;
    end else if (e[1]) begin
      m_wr = 0; m_rd = 0; m_st = 2; m_full = 0; m_cnt = n;
    end else if (e[2]) begin
      m_st = m_st & 12;
    end else if (act == 1) begin
      if (e[3]) begin
        m_wr = (m_wr + 1) % D;
        if (m_wr == m_rd) m_st = m_st | 4;
      end
      if (e[6] && m_rd != m_wr) m_rd = (m_rd + 1) % D;
      if (e[4]) m_st = m_st | 8;
    end else if (act == 2) begin
      if (e[3]) begin
        m_rd = (m_rd + 1) % D;
        m_full = 0;
        if (m_rd == m_wr) m_st = m_st | 4;
      end
      if (e[7] && !(m_wr == m_rd && m_full == 1)) begin
        m_wr = (m_wr + 1) % D;
        if (m_wr == m_rd) m_full = 1;
      end
      if (e[5] && m_cnt > 0) begin
        if (m_cnt == D + 1) begin
          m_term = 1; m_slot = m_rd;
        end
        m_cnt = m_cnt - 1;
      end
      if (e[4]) m_st = m_st | 8;
    end
    @(negedge clk);
    {start_rd, start_wr, stop, blk_end, dp_err, xfer_done, pop, push} = '0;
    chk_all(tag);
  endtask

  localparam logic [7:0] E_SRD = 8'h01, E_SWR = 8'h02, E_STOP = 8'h04, E_BLK = 8'h08,
                         E_ERR = 8'h10, E_XFER = 8'h20, E_POP = 8'h40, E_PUSH = 8'h80;

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {start_rd, start_wr, stop, blk_end, dp_err, xfer_done, pop, push} = '0;
    blk_cnt = '0;
    m_wr = 0; m_rd = 0; m_st = 0; m_cnt = 0; m_full = 0; m_term = 0; m_slot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // R11: strobes while idle after reset change nothing
    ev(E_BLK, 0, "R11"); ev(E_ERR, 0, "R11"); ev(E_PUSH, 0, "R11"); ev(E_POP, 0, "R11");

    // R2 / R4: read with interleaved pops, wrapping twice
    ev(E_SRD, 0, "R2");
    ev(E_POP, 0, "R4");                         // refused: ring empty
    for (int k = 0; k < 9; k++) begin
      ev(E_BLK, 0, "R4");
      ev(E_POP, 0, "R4");
    end
    // R5: let the ring fill without draining
    for (int k = 0; k < D; k++) ev(E_BLK, 0, "R5");
    ev(E_POP, 0, "R12");
    ev(E_IDLE_OF(), 0, "R12");

    // R5 sweep: host lags by j blocks before overrun
    for (int j = 0; j < D; j++) begin
      ev(E_SRD, 0, "R2");
      for (int k = 0; k < j; k++) ev(E_BLK, 0, "R4");
      for (int k = 0; k < j; k++) ev(E_POP, 0, "R4");
      for (int k = 0; k < D; k++) ev(E_BLK, 0, "R5");
    end

    // R8: error in read mode, then R12 start clears it
    ev(E_SRD, 0, "R2");
    ev(E_ERR, 0, "R8");
    ev(E_BLK, 0, "R12");
    ev(E_SRD | E_SWR, 3, "R2");                 // read wins

    // R3 / R6 / R7 / R10: write of 7 blocks
    ev(E_SWR, 7, "R3");
    for (int k = 0; k < D + 1; k++) ev(E_PUSH, 0, "R6"); // last one refused
    for (int k = 0; k < 3; k++) ev(E_XFER, 0, "R10");
    ev(8'h00, 0, "R10");
    for (int k = 0; k < 2; k++) ev(E_BLK, 0, "R6");
    ev(E_PUSH, 0, "R6");
    for (int k = 0; k < 3; k++) ev(E_BLK, 0, "R7");
    ev(E_XFER, 0, "R10");

    // R10 sweep: every count 1..8 through the countdown
    for (int n = 1; n <= 8; n++) begin
      ev(E_SWR, n, "R3");
      ev(E_BLK, 0, "R7");
      for (int k = 0; k < n + 1; k++) begin
        ev(E_XFER, 0, "R10");
        ev(8'h00, 0, "R10");
      end
    end

    // R10: slot reported follows the consumer index
    ev(E_SWR, 6, "R3");
    for (int k = 0; k < 3; k++) ev(E_PUSH, 0, "R6");
    ev(E_BLK, 0, "R6");
    ev(E_XFER, 0, "R10");
    ev(E_XFER, 0, "R10");

    // R8 in write mode, R11 stop keeps flags, then ignores strobes
    ev(E_ERR, 0, "R8");
    ev(E_STOP, 0, "R11");
    ev(E_BLK, 0, "R11"); ev(E_PUSH, 0, "R11"); ev(E_XFER, 0, "R11"); ev(E_ERR, 0, "R11");
    ev(E_SRD, 0, "R12");
    ev(E_STOP, 0, "R11");
    ev(E_BLK, 0, "R11"); ev(E_POP, 0, "R11");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [7:0] E_IDLE_OF();
    return 8'h00;
  endfunction
endmodule